// File: doc/BRIEF.md
# Iterative AES-128 Round Controller

This block encrypts one 128-bit block with a 128-bit key under AES-128, reusing one round datapath for every round. A nine-state sequencer steps the data through the key-whitening step, nine full rounds and a last round that has no column mixing. Its byte-substitution stage has a registered output, and its next-round-key logic takes two registered stages. Dedicated wait states give each of these time to settle before its result is consumed.

Two selectors choose the inputs of the shared key-addition XOR according to the sequencer state. The data input is the plaintext at start, the mixed columns in a full round, the latched shifted rows in the last round, and the held state otherwise. The key input is the cipher key at start, the saved tenth round key in the last round, and the freshly expanded key otherwise.

A host drives `load` high to abort any work in progress and arm the block. It then drops `load` and waits for `done`, while the ciphertext stays available on the output.

Top module: `aes128_iter`

## Requirements
- R1: While `rst_n` is low and after it is released, `done` is 0 until an encryption has finished.
- R2: Every rising edge with `load` high returns the sequencer to its start state and clears `done`. This holds even in the middle of an encryption. `done` stays 0 for as long as `load` is held high.
- R3: `plaintext` and `key` are sampled only on the first rising edge at which `load` is low. Changing them afterwards has no effect on the result.
- R4: The key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff yields ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: Call the first rising edge with `load` low edge 1. `done` first reads 1 after edge 45, and is 0 after edges 1 to 44.
- R6: Once `done` is 1 it stays 1, and `ciphertext` stays constant, until `load` is raised again.
- R7: Bits [127:120] of each 128-bit word are byte 0. Byte i sits in row i mod 4 and column i div 4 of the state. For example, an all-zero key and plaintext yield 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R8: For any key and plaintext, `ciphertext` equals the AES-128 encryption of that block when `done` is 1.
- R9: The sequencer never leaves its nine legal states, and the round counter never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Abort and arm; encryption starts on the first edge with it low |
| plaintext | input | 128 | Block to encrypt, byte 0 in bits [127:120] |
| key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| ciphertext | output | 128 | Encrypted block, valid while `done` is 1 |
| done | output | 1 | Encryption finished |

## Verification
The published test vector checks the whole round sequence at once. The all-zero block and key check byte ordering, because their substitution values are uniform and any misplaced row shows up in the result. Seeded random blocks and keys exercise the round-constant chain and the column mixing over data that no directed case covers. Three further cases separate sampling from holding and restart from completion: a load pulse in the middle of a run, a load held high for a long time, and input changes after the start edge.

// File: rtl/aes128_iter.sv
module aes128_iter (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [127:0] plaintext,
  input  logic [127:0] key,
  output logic [127:0] ciphertext,
  output logic         done
);

  localparam logic [3:0] LAST_MIX_ROUND = 4'd9;

  typedef enum logic [3:0] {
    S0 = 4'd0, S1 = 4'd1, S2 = 4'd2, S3 = 4'd3, S4 = 4'd4,
    S5 = 4'd5, S6 = 4'd6, S7 = 4'd7, S8 = 4'd8
  } fsm_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] sq, inv;
    sq  = x;
    inv = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] sub_bytes(input logic [127:0] s);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = sbox(s[127-8*i -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] shift_rows(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(r+4*c) -: 8] = s[127-8*(r+4*((c+r)%4)) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] mix_cols(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      o[119-32*c -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      o[111-32*c -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      o[103-32*c -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return o;
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++)
      if (i < int'(n)) r = xt(r);
    return r;
  endfunction

  function automatic logic [127:0] next_key(input logic [127:0] k,
                                            input logic [31:0]  sw,
                                            input logic [7:0]   rc);
    logic [31:0] w0, w1, w2, w3;
    w0 = k[127:96] ^ sw ^ {rc, 24'h0};
    w1 = k[95:64] ^ w0;
    w2 = k[63:32] ^ w1;
    w3 = k[31:0]  ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  fsm_t         fsm;
  logic [3:0]   round;
  logic [127:0] st, rkey, sb_q, kx_q, fin_reg, fin_key;
  logic [31:0]  kw_q;
  logic [127:0] ark_in, ark_key, ark_out;

  assign ark_in  = (fsm == S0) ? plaintext :
                   (fsm == S4) ? mix_cols(shift_rows(sb_q)) :
                   (fsm == S7) ? fin_reg : st;
  assign ark_key = (fsm == S0) ? key :
                   (fsm == S7) ? fin_key : kx_q;
  assign ark_out = ark_in ^ ark_key;

  assign ciphertext = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_q <= '0;
      kw_q <= '0;
      kx_q <= '0;
    end else begin
      sb_q <= sub_bytes(st);
      kw_q <= {sbox(rkey[23:16]), sbox(rkey[15:8]), sbox(rkey[7:0]), sbox(rkey[31:24])};
      kx_q <= next_key(rkey, kw_q, rcon(round + 4'd1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm     <= S0;
      round   <= '0;
      done    <= 1'b0;
      st      <= '0;
      rkey    <= '0;
      fin_reg <= '0;
      fin_key <= '0;
    end else if (load) begin
      fsm   <= S0;
      round <= '0;
      done  <= 1'b0;
    end else begin
      unique case (fsm)
        S0: begin
          st   <= ark_out;
          rkey <= key;
          fsm  <= S1;
        end
        S1: fsm <= S2;
        S2: fsm <= S3;
        S3: fsm <= S4;
        S4: begin
          rkey <= kx_q;
          if (round < LAST_MIX_ROUND) begin
            st    <= ark_out;
            round <= round + 4'd1;
            fsm   <= S1;
          end else begin
            fin_key <= kx_q;
            fsm     <= S5;
          end
        end
        S5: begin
          fin_reg <= shift_rows(sb_q);
          fsm     <= S6;
        end
        S6: fsm <= S7;
        S7: begin
          st  <= ark_out;
          fsm <= S8;
        end
        S8: done <= 1'b1;
        default: fsm <= S0;
      endcase
    end
  end

endmodule

// File: rtl/aes128_iter_chk.sv
module aes128_iter_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic         done,
  input logic [127:0] ct,
  input logic [3:0]   fsm,
  input logic [3:0]   round
);

  AST_FSM_LEGAL:   assert property (@(posedge clk) disable iff (!rst_n) fsm <= 4'd8); // R9
  AST_ROUND_MAX:   assert property (@(posedge clk) disable iff (!rst_n) round <= 4'd9); // R9
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) load |=> (!done && fsm == 4'd0)); // R2
  AST_DONE_FINAL:  assert property (@(posedge clk) disable iff (!rst_n) done |-> fsm == 4'd8); // R5
  AST_START_STEP:  assert property (@(posedge clk) disable iff (!rst_n) (!load && fsm == 4'd0) |=> fsm == 4'd1); // R5
  AST_DONE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (done && !load) |=> (done && $stable(ct))); // R6

endmodule

bind aes128_iter aes128_iter_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .load  (load),
  .done  (done),
  .ct    (ciphertext),
  .fsm   (fsm),
  .round (round)
);

// File: tb/aes128_iter_tb.sv
module aes128_iter_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] plaintext = '0;
  logic [127:0] key = '0;
  logic [127:0] ciphertext;
  logic         done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] sb_t [256];

  always #4 clk = ~clk;

  aes128_iter u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .plaintext(plaintext),
    .key(key), .ciphertext(ciphertext), .done(done)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m2(input logic [7:0] a);
    return a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = m2(x);
    end
    return p;
  endfunction

  task automatic build_sbox();
    logic [7:0] inv, c;
    c = 8'h63;
    for (int x = 0; x < 256; x++) begin
      inv = 0;
      for (int y = 1; y < 256; y++)
        if (mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        sb_t[x][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0]  rc, a0, a1, a2, a3;
    logic [127:0] o;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    rc = 8'h01;
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sb_t[tmp[23:16]] ^ rc, sb_t[tmp[15:8]], sb_t[tmp[7:0]], sb_t[tmp[31:24]]};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = sb_t[s[i]];
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++) s[q+4*c] = t[q+4*((c+q)%4)];
      if (r < 10)
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = mul(a0, 2) ^ mul(a1, 3) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ mul(a1, 2) ^ mul(a2, 3) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ mul(a2, 2) ^ mul(a3, 3);
          s[4*c+3] = mul(a0, 3) ^ a1 ^ a2 ^ mul(a3, 2);
        end
      for (int i = 0; i < 16; i++) s[i] ^= w[4*r + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // Starts an encryption, scrambles the inputs after the start edge (R3),
  // checks latency (R5), result, and hold behaviour (R6).
  task automatic run(input logic [127:0] p, input logic [127:0] k,
                     input logic [127:0] exp, input string req);
    int n;
    @(negedge clk);
    load = 1'b1; plaintext = p; key = k;
    @(negedge clk);
    load = 1'b0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      n++;
      if (n == 1) begin plaintext = rnd128(); key = rnd128(); end
      if (done) break;
    end
    check("R5 latency", 128'(n), 128'd45);
    check(req, ciphertext, exp);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      plaintext = rnd128();
      key = rnd128();
    end
    check("R6 done held", 128'(done), 128'd1);
    check("R6 R3 ciphertext held", ciphertext, exp);
  endtask

  initial begin
    logic [127:0] p, k;
    process::self().srandom(32'h5eed_0a35);
    build_sbox();
    repeat (3) @(negedge clk);
    check("R1 done in reset", 128'(done), 128'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after reset", 128'(done), 128'd0);

    p = 128'h00112233445566778899aabbccddeeff;
    k = 128'h000102030405060708090a0b0c0d0e0f;
    check("R4 model vector", ref_enc(p, k), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run(p, k, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 published vector");

    run('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R7 zero block byte order");

    // R2: restart in the middle of a run
    @(negedge clk);
    load = 1'b1; plaintext = rnd128(); key = rnd128();
    @(negedge clk);
    load = 1'b0;
    repeat (20) @(negedge clk);
    p = rnd128(); k = rnd128();
    run(p, k, ref_enc(p, k), "R2 restart mid-run");

    // R2: load held high keeps done low
    @(negedge clk);
    load = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check("R2 done low while load held", 128'(seen), 128'd0);
    end
    load = 1'b0;

    for (int v = 0; v < 8; v++) begin
      p = rnd128(); k = rnd128();
      run(p, k, ref_enc(p, k), "R8 random vector");
    end

    p = '1; k = '1;
    run(p, k, ref_enc(p, k), "R8 all-ones vector");

    finish_run();
  end

endmodule